// File: doc/BRIEF.md
# Banked Single-Port Synchronous RAM

This block is a single-port synchronous memory of 16K words, each word holding an 8-bit data byte and one parity bit that is stored and returned but never checked. Storage is split into eight banks of 2K words. The top address bits choose which bank sees the access, and the low eleven bits address a word inside that bank. Only the chosen bank is enabled on a given edge.

Reads take one clock. The bank index goes into a register at the same edge as the read, and a multiplexer after the banks uses it to pick the returned word. A synchronous output reset, qualified by the enable, loads a parameter value into the output without touching memory. A parameter selects the read-during-write behaviour: old contents, new data, or no change at the output.

Top module: `banked_spram`

## Requirements
- R1: When `en` is high and `we` is low, the word at `addr` (data on `dout`, parity on `dout_par`) appears on the outputs after the next rising clock edge and stays there until the next enabled edge.
- R2: Address bits 13..11 select one of eight banks and bits 10..0 the word within it. A write changes only the addressed word, so addresses that differ only in bits 13..11 hold independent words.
- R3: When `en` is low, nothing is written and both outputs hold their values, whatever `we`, `ssr`, `addr` and the data inputs do.
- R4: When `en` and `ssr` are both high at an edge, the outputs become `RST_DATA`/`RST_PAR` (zero by default) after that edge, whatever the read. Memory contents are unchanged.
- R5: With `RDW_MODE` set to write-first, an enabled write without `ssr` shows the data and parity being written on the outputs after that edge.
- R6: With `RDW_MODE` set to read-first, an enabled write without `ssr` shows the word's previous contents on the outputs after that edge.
- R7: With `RDW_MODE` set to no-change, an enabled write leaves both outputs unchanged, including a value left by an earlier reset.
- R8: While `rst_n` is low and after it is released, the outputs show `RST_DATA`/`RST_PAR` until the first enabled read.
- R9: A write that occurs at the same edge as `ssr` is still stored in memory.
- R10: Back-to-back reads of different banks on consecutive edges each return the word of the address presented one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Access enable; gates read, write and output reset |
| we | input | 1 | Write enable |
| ssr | input | 1 | Synchronous output reset |
| addr | input | 14 | Word address: bank in bits 13..11, word in bits 10..0 |
| din | input | 8 | Write data |
| din_par | input | 1 | Write parity bit |
| dout | output | 8 | Read data |
| dout_par | output | 1 | Read parity bit |

## Verification
Three instances, one per read-during-write mode, get the same stimulus and are checked against a behavioural reference on every clock. Directed patterns write the same in-bank offset in all eight banks and read them back in a row, which separates a correct bank decode and delayed output select from one that aliases banks or uses the current address. Writes with the enable low, resets with a read or a write, and writes to words read just before separate the hold, priority and mode behaviours. A long run of pseudo-random operations over a small pool of addresses then mixes all of these orderings.

// File: rtl/bram_pkg.sv
package bram_pkg;
  typedef enum logic [1:0] {
    RDW_READ_FIRST  = 2'd0,
    RDW_WRITE_FIRST = 2'd1,
    RDW_NO_CHANGE   = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/spram_bank_decode.sv
module spram_bank_decode #(
  parameter int NBANKS = 8,
  parameter int SEL_W  = 3
) (
  input  logic             en,
  input  logic [SEL_W-1:0] bank_sel,
  output logic [NBANKS-1:0] bank_en
);
  for (genvar gi = 0; gi < NBANKS; gi++) begin : g_dec
    assign bank_en[gi] = en && (bank_sel == SEL_W'(gi));
  end
endmodule

// File: rtl/spram_bank.sv
module spram_bank
  import bram_pkg::*;
#(
  parameter int        WORD_W   = 9,
  parameter int        AW       = 11,
  parameter rdw_mode_e RDW_MODE = RDW_READ_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_en,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_d, rd_q;

  // storage array: no reset, written only when this bank is enabled
  always_ff @(posedge clk) begin
    if (bank_en && we) begin
      mem[waddr] <= wword;
    end
  end

  // read register next state, chosen by the read-during-write variant
  always_comb begin
    rd_d = rd_q;
    if (bank_en) begin
      case (RDW_MODE)
        RDW_WRITE_FIRST: rd_d = we ? wword : mem[waddr];
        RDW_NO_CHANGE:   if (!we) rd_d = mem[waddr];
        default:         rd_d = mem[waddr];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rword = rd_q;

  // a bank that is not addressed keeps its read register
  assert_unselected_hold_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !bank_en |=> $stable(rword))
    else $error("unselected bank changed its read word");

  if (RDW_MODE == RDW_WRITE_FIRST) begin : g_wf_chk
    assert_bank_write_first_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bank_en && we) |=> (rword == $past(wword)))
      else $error("write-first bank did not return written word");
  end
endmodule

// File: rtl/spram_out_select.sv
module spram_out_select
  import bram_pkg::*;
#(
  parameter int                  NBANKS   = 8,
  parameter int                  SEL_W    = 3,
  parameter int                  WORD_W   = 9,
  parameter rdw_mode_e           RDW_MODE = RDW_READ_FIRST,
  parameter logic [WORD_W-1:0]   RST_WORD = '0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           we,
  input  logic                           ssr,
  input  logic [SEL_W-1:0]               bank_sel,
  input  logic [NBANKS-1:0][WORD_W-1:0]  bank_words,
  output logic [WORD_W-1:0]              out_word
);
  localparam bit HOLD_ON_WRITE = (RDW_MODE == RDW_NO_CHANGE);

  logic [SEL_W-1:0] sel_d, sel_q;
  logic             rst_d, rst_q;

  always_comb begin
    sel_d = sel_q;
    rst_d = rst_q;
    if (en) begin
      if (ssr) begin
        rst_d = 1'b1;
      end else if (!(we && HOLD_ON_WRITE)) begin
        rst_d = 1'b0;
        sel_d = bank_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      rst_q <= 1'b1;
    end else begin
      sel_q <= sel_d;
      rst_q <= rst_d;
    end
  end

  assign out_word = rst_q ? RST_WORD : bank_words[sel_q];

  assert_idle_hold_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_word))
    else $error("output moved while disabled");

  assert_sreset_value_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (en && ssr) |=> (out_word == RST_WORD))
    else $error("output reset value not applied");

  if (HOLD_ON_WRITE) begin : g_nc_chk
    assert_no_change_hold_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      (en && we && !ssr) |=> $stable(out_word))
      else $error("no-change write moved the output");
  end
endmodule

// File: rtl/banked_spram.sv
module banked_spram
  import bram_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          PAR_W    = 1,
  parameter int          ADDR_W   = 14,
  parameter int          BANK_AW  = 11,
  parameter rdw_mode_e   RDW_MODE = RDW_READ_FIRST,
  parameter logic [DATA_W-1:0] RST_DATA = '0,
  parameter logic [PAR_W-1:0]  RST_PAR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic              ssr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [PAR_W-1:0]  din_par,
  output logic [DATA_W-1:0] dout,
  output logic [PAR_W-1:0]  dout_par
);
  localparam int SEL_W  = ADDR_W - BANK_AW;
  localparam int NBANKS = 1 << SEL_W;
  localparam int WORD_W = DATA_W + PAR_W;
  localparam logic [WORD_W-1:0] RST_WORD = {RST_PAR, RST_DATA};

  logic [SEL_W-1:0]                bank_sel;
  logic [BANK_AW-1:0]              word_addr;
  logic [NBANKS-1:0]               bank_en;
  logic [NBANKS-1:0][WORD_W-1:0]   bank_words;
  logic [WORD_W-1:0]               wword;
  logic [WORD_W-1:0]               out_word;

  assign bank_sel  = addr[ADDR_W-1:BANK_AW];
  assign word_addr = addr[BANK_AW-1:0];
  assign wword     = {din_par, din};

  spram_bank_decode #(
    .NBANKS (NBANKS),
    .SEL_W  (SEL_W)
  ) u_decode (
    .en       (en),
    .bank_sel (bank_sel),
    .bank_en  (bank_en)
  );

  for (genvar gb = 0; gb < NBANKS; gb++) begin : g_bank
    spram_bank #(
      .WORD_W   (WORD_W),
      .AW       (BANK_AW),
      .RDW_MODE (RDW_MODE)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_en (bank_en[gb]),
      .we      (we),
      .waddr   (word_addr),
      .wword   (wword),
      .rword   (bank_words[gb])
    );
  end

  spram_out_select #(
    .NBANKS   (NBANKS),
    .SEL_W    (SEL_W),
    .WORD_W   (WORD_W),
    .RDW_MODE (RDW_MODE),
    .RST_WORD (RST_WORD)
  ) u_outsel (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .we         (we),
    .ssr        (ssr),
    .bank_sel   (bank_sel),
    .bank_words (bank_words),
    .out_word   (out_word)
  );

  assign {dout_par, dout} = out_word;

  if (RDW_MODE == RDW_WRITE_FIRST) begin : g_top_wf_chk
    assert_write_first_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (en && we && !ssr) |=> ({dout_par, dout} == $past({din_par, din})))
      else $error("write-first output mismatch");
  end

  if (RDW_MODE == RDW_READ_FIRST) begin : g_top_rf_chk
    assert_read_sel_R10: assert property (
      @(posedge clk) disable iff (!rst_n)
      (en && !ssr) |=> ({dout_par, dout} == bank_words[$past(bank_sel)]))
      else $error("output not from previously addressed bank");
  end
endmodule

// File: tb/banked_spram_tb_top.sv
module banked_spram_tb_top;
  import bram_pkg::*;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16384;
  localparam logic [8:0] RSTW = 9'h000;

  logic clk;
  logic rst_n, en, we, ssr;
  logic [13:0] addr;
  logic [7:0]  din;
  logic [0:0]  din_par;
  logic [7:0]  rf_d, wf_d, nc_d;
  logic [0:0]  rf_p, wf_p, nc_p;

  int n_checks = 0;
  int n_errs   = 0;

  logic [8:0] ref_mem [DEPTH];
  bit         ref_ok  [DEPTH];
  logic [8:0] exp_rf, exp_wf, exp_nc;
  bit         ok_rf, ok_wf, ok_nc;

  banked_spram #(.RDW_MODE(RDW_READ_FIRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .ssr(ssr), .addr(addr),
    .din(din), .din_par(din_par), .dout(rf_d), .dout_par(rf_p));

  banked_spram #(.RDW_MODE(RDW_WRITE_FIRST)) dut_wf_i (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .ssr(ssr), .addr(addr),
    .din(din), .din_par(din_par), .dout(wf_d), .dout_par(wf_p));

  banked_spram #(.RDW_MODE(RDW_NO_CHANGE)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .ssr(ssr), .addr(addr),
    .din(din), .din_par(din_par), .dout(nc_d), .dout_par(nc_p));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input string who,
                       input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %03h expected %03h", tag, who, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    if (ok_rf) check(tag, "read-first", {rf_p, rf_d}, exp_rf);
    if (ok_wf) check(tag, "write-first", {wf_p, wf_d}, exp_wf);
    if (ok_nc) check(tag, "no-change", {nc_p, nc_d}, exp_nc);
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic step(input logic e, input logic w, input logic s, input int a,
                      input logic [7:0] d, input logic p, input string tag);
    logic [8:0] old;
    bit         old_ok;
    en = e; we = w; ssr = s; addr = a[13:0]; din = d; din_par = p;
    @(posedge clk);
    if (e) begin
      old    = ref_mem[a];
      old_ok = ref_ok[a];
      if (s) begin
        exp_rf = RSTW; exp_wf = RSTW; exp_nc = RSTW;
        ok_rf = 1; ok_wf = 1; ok_nc = 1;
      end else if (w) begin
        exp_rf = old; ok_rf = old_ok;
        exp_wf = {p, d}; ok_wf = 1;
      end else begin
        exp_rf = old; exp_wf = old; exp_nc = old;
        ok_rf = old_ok; ok_wf = old_ok; ok_nc = old_ok;
      end
      if (w) begin
        ref_mem[a] = {p, d};
        ref_ok[a]  = 1;
      end
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_ok[i] = 0;
    rst_n = 1'b0; en = 0; we = 0; ssr = 0; addr = '0; din = '0; din_par = '0;
    exp_rf = RSTW; exp_wf = RSTW; exp_nc = RSTW;
    ok_rf = 1; ok_wf = 1; ok_nc = 1;
    repeat (3) @(negedge clk);
    compare_all("R8");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 8'h00, 0, "R8");

    // same offset in every bank: R2
    for (int b = 0; b < 8; b++)
      step(1, 1, 0, (b << 11) | 5, 8'(8'h11 * b + 3), 1'(b), "R2");
    // back-to-back reads across banks: R10, R1
    for (int b = 7; b >= 0; b--)
      step(1, 0, 0, (b << 11) | 5, 8'h00, 0, "R10");
    step(1, 0, 0, 16383, 8'h00, 0, "R1");
    step(1, 1, 0, 16383, 8'hA5, 1, "R1");
    step(1, 0, 0, 0, 8'h00, 0, "R1");
    step(1, 0, 0, 16383, 8'h00, 0, "R1");

    // enable low: nothing changes, R3
    step(0, 1, 0, (3 << 11) | 5, 8'hEE, 0, "R3");
    step(0, 0, 1, (2 << 11) | 5, 8'h00, 0, "R3");
    step(1, 0, 0, (3 << 11) | 5, 8'h00, 0, "R3");

    // synchronous output reset: R4, R9
    step(1, 0, 1, (4 << 11) | 5, 8'h00, 0, "R4");
    step(0, 0, 0, (4 << 11) | 5, 8'h00, 0, "R4");
    step(1, 0, 0, (4 << 11) | 5, 8'h00, 0, "R4");
    step(1, 1, 1, (6 << 11) | 9, 8'h3C, 1, "R9");
    step(1, 1, 0, (6 << 11) | 10, 8'h77, 0, "R7");
    step(1, 0, 0, (6 << 11) | 9, 8'h00, 0, "R9");

    // read-during-write on a word read the cycle before: R5, R6, R7
    step(1, 0, 0, (1 << 11) | 5, 8'h00, 0, "R6");
    step(1, 1, 0, (1 << 11) | 5, 8'h5A, 1, "R5");
    step(1, 1, 0, (2 << 11) | 5, 8'hC3, 0, "R7");
    step(1, 1, 0, (1 << 11) | 5, 8'h96, 0, "R6");
    step(1, 0, 0, (2 << 11) | 5, 8'h00, 0, "R1");

    // mixed pseudo-random traffic over a small address pool
    void'($urandom(32'd7));
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      int a;
      r = $urandom;
      a = ((r >> 4) & 7) << 11 | ((r >> 8) & 15) | (((r >> 12) & 1) << 10);
      step((r & 7) != 0, r[3], (r[20:16] == 0), a, 8'(r >> 21), r[29], "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule